// File: doc/BRIEF.md
# Dual Decrementing Counters with Shared Freeze

The block keeps two unsigned counters of the same width. Counter A takes a parallel value and counts down by one. Counter B takes its own parallel value and counts down by a step amount. That step comes from a separate input, which is assumed stable and is used without a register. A single status output, `halt`, is high in two cases: the two counts are equal, or an earlier decrement wrapped a counter below zero. While `halt` is high, both counters ignore their decrement strobes. A load of either counter is the only way to start counting again.

Each counter lets a load override a decrement in the same cycle, and a load is accepted even while the block is frozen. A wraparound still stores the wrapped value. It also sets a sticky bit, and any load clears that bit. `halt` is combinational from the stored counts and the sticky bit, so it follows the new contents one cycle after a reload. A synchronous active-low reset clears both counts and the sticky bit.

Top module: `dual_dec_counter`

## Requirements
- R1: With `rst_n` low at a rising clock edge, both counts become 0 and the sticky wrap bit clears, so `halt` reads 1 after the edge.
- R2: With `ld_a` high at an edge, `cnt_a` takes `val_a`. This wins over `dn_a` in the same cycle and also works while `halt` is high.
- R3: With `ld_b` high at an edge, `cnt_b` takes `val_b`. This wins over `dn_b` in the same cycle and also works while `halt` is high.
- R4: With `dn_a` high, `ld_a` low and `halt` low, `cnt_a` decreases by exactly 1 at the edge.
- R5: With `dn_b` high, `ld_b` low and `halt` low, `cnt_b` decreases by `step_b` modulo 2^W at the edge. A step of 0 leaves the count unchanged.
- R6: `halt` is high whenever `cnt_a` equals `cnt_b`.
- R7: A counter wraps when its decrement amount is larger than its current count. The wrapped value is stored, and `halt` is high from the next cycle until a load occurs.
- R8: While `halt` is high, `dn_a` and `dn_b` have no effect and a counter that is not being loaded keeps its value.
- R9: Any load clears the sticky wrap bit, so afterwards `halt` depends only on the new counts. A wrap by the other counter in that same cycle sets the bit again.
- R10: A counter whose load and decrement strobes are both low keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| val_a | input | W | Parallel value for counter A |
| val_b | input | W | Parallel value for counter B |
| step_b | input | W | Decrement amount for counter B |
| ld_a | input | 1 | Load strobe for counter A |
| ld_b | input | 1 | Load strobe for counter B |
| dn_a | input | 1 | Decrement-by-one strobe for counter A |
| dn_b | input | 1 | Decrement-by-step strobe for counter B |
| cnt_a | output | W | Counter A contents |
| cnt_b | output | W | Counter B contents |
| halt | output | 1 | High on equal counts or a pending wraparound |

## Verification
The stimulus first counts down two unequal starting values until they meet. This separates a correct equality freeze from one that misses by a cycle or lets counting run past the match. Separate cases wrap counter B with a step larger than its count, and wrap counter A at zero. Together they tell the sticky wrap path apart from the equality path, because the wrapped counts differ and `halt` must still stay high. Further cases cover a load combined with a blocked decrement, a load on one counter while the other wraps in the same cycle, a zero step, and equal values loaded directly. These show load priority, clearing of the sticky bit, and the release that only a reload provides.

// File: rtl/dual_dec_counter.sv
module dual_dec_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  input  logic [W-1:0] step_b,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic         dn_a,
  input  logic         dn_b,
  output logic [W-1:0] cnt_a,
  output logic [W-1:0] cnt_b,
  output logic         halt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic wrap_q;
  logic go_a, go_b, wrap_a, wrap_b;

  assign halt   = (cnt_a == cnt_b) | wrap_q;
  assign go_a   = dn_a & ~ld_a & ~halt;
  assign go_b   = dn_b & ~ld_b & ~halt;
  assign wrap_a = go_a & (cnt_a < ONE);
  assign wrap_b = go_b & (step_b > cnt_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_a  <= '0;
      cnt_b  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (ld_a)      cnt_a <= val_a;
      else if (go_a) cnt_a <= cnt_a - ONE;
      if (ld_b)      cnt_b <= val_b;
      else if (go_b) cnt_b <= cnt_b - step_b;
      wrap_q <= (wrap_q & ~(ld_a | ld_b)) | wrap_a | wrap_b;
    end
  end
endmodule

// File: rtl/dual_dec_counter_chk.sv
module dual_dec_counter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] val_a,
  input logic [W-1:0] val_b,
  input logic [W-1:0] step_b,
  input logic         ld_a,
  input logic         ld_b,
  input logic         dn_a,
  input logic         dn_b,
  input logic [W-1:0] cnt_a,
  input logic [W-1:0] cnt_b,
  input logic         halt
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (cnt_a == '0) && (cnt_b == '0) && halt);

  a_r2_load_a: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> cnt_a == $past(val_a));

  a_r3_load_b: assert property (@(posedge clk) disable iff (!rst_n)
    ld_b |=> cnt_b == $past(val_b));

  a_r4_dec_a: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_a && !ld_a && !halt) |=> cnt_a == W'($past(cnt_a) - W'(1)));

  a_r5_dec_b: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_b && !ld_b && !halt) |=> cnt_b == W'($past(cnt_b) - $past(step_b)));

  a_r6_equal_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a == cnt_b) |-> halt);

  a_r7_wrap_b_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_b && !ld_b && !halt && (step_b > cnt_b)) |=> halt);

  a_r7_wrap_a_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_a && !ld_a && !halt && (cnt_a == '0)) |=> halt);

  a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ld_a && !ld_b) |=> $stable(cnt_a) && $stable(cnt_b) && halt);

  a_r10_idle_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_a && !dn_a) |=> $stable(cnt_a));

  a_r10_idle_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_b && !dn_b) |=> $stable(cnt_b));
endmodule

bind dual_dec_counter dual_dec_counter_chk #(.W(W)) u_chk (.*);

// File: tb/tb_dual_dec_counter.sv
`timescale 1ns/1ps
module tb_dual_dec_counter;
  localparam int W = 8;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] val_a, val_b, step_b;
  logic ld_a, ld_b, dn_a, dn_b;
  logic [W-1:0] cnt_a, cnt_b;
  logic halt;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_dec_counter #(.W(W)) dut (.*);

  // {ld_a, ld_b, dn_a, dn_b, val_a, val_b, step_b, exp_a, exp_b, exp_halt}
  localparam logic [44:0] VEC [NV] = '{
    {4'b1100, 8'd10,  8'd20, 8'd3, 8'd10,  8'd20,  1'b0}, // R2 R3 load both
    {4'b0011, 8'd0,   8'd0,  8'd3, 8'd9,   8'd17,  1'b0}, // R4 R5
    {4'b0010, 8'd0,   8'd0,  8'd3, 8'd8,   8'd17,  1'b0}, // R4 R10
    {4'b0001, 8'd0,   8'd0,  8'd3, 8'd8,   8'd14,  1'b0}, // R5
    {4'b0001, 8'd0,   8'd0,  8'd3, 8'd8,   8'd11,  1'b0}, // R5
    {4'b0001, 8'd0,   8'd0,  8'd3, 8'd8,   8'd8,   1'b1}, // R6 counts meet
    {4'b0011, 8'd0,   8'd0,  8'd3, 8'd8,   8'd8,   1'b1}, // R8 frozen
    {4'b1000, 8'd5,   8'd0,  8'd3, 8'd5,   8'd8,   1'b0}, // R2 load releases
    {4'b0000, 8'd0,   8'd0,  8'd3, 8'd5,   8'd8,   1'b0}, // R10 idle
    {4'b0001, 8'd0,   8'd0,  8'd3, 8'd5,   8'd5,   1'b1}, // R6
    {4'b0110, 8'd0,   8'd1,  8'd3, 8'd5,   8'd1,   1'b0}, // R3 R8 dec blocked
    {4'b0011, 8'd0,   8'd0,  8'd3, 8'd4,   8'd254, 1'b1}, // R7 wrap b
    {4'b0010, 8'd0,   8'd0,  8'd3, 8'd4,   8'd254, 1'b1}, // R7 R8 sticky
    {4'b1010, 8'd0,   8'd0,  8'd3, 8'd0,   8'd254, 1'b0}, // R2 R9 load clears
    {4'b0010, 8'd0,   8'd0,  8'd3, 8'd255, 8'd254, 1'b1}, // R7 wrap a
    {4'b1100, 8'd100, 8'd50, 8'd3, 8'd100, 8'd50,  1'b0}, // R9
    {4'b0011, 8'd0,   8'd0,  8'd0, 8'd99,  8'd50,  1'b0}, // R5 zero step
    {4'b0100, 8'd0,   8'd2,  8'd3, 8'd99,  8'd2,   1'b0}, // R3
    {4'b1001, 8'd7,   8'd0,  8'd3, 8'd7,   8'd255, 1'b1}, // R9 load with wrap
    {4'b0010, 8'd0,   8'd0,  8'd3, 8'd7,   8'd255, 1'b1}  // R8
  };

  task automatic check(string tag, logic [W-1:0] ea, logic [W-1:0] eb, logic eh);
    n_chk++;
    if (cnt_a !== ea || cnt_b !== eb || halt !== eh) begin
      n_fail++;
      $display("FAIL %s: got a=%0d b=%0d halt=%0b, expected a=%0d b=%0d halt=%0b",
               tag, cnt_a, cnt_b, halt, ea, eb, eh);
    end
  endtask

  task automatic drive(logic la, logic lb, logic da, logic db,
                       logic [W-1:0] va, logic [W-1:0] vb, logic [W-1:0] st);
    {ld_a, ld_b, dn_a, dn_b} = {la, lb, da, db};
    val_a = va; val_b = vb; step_b = st;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    {ld_a, ld_b, dn_a, dn_b} = 4'b0;
    val_a = '0; val_b = '0; step_b = '0;
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0);
    check("R1 reset state", 8'd0, 8'd0, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][44], VEC[i][43], VEC[i][42], VEC[i][41],
            VEC[i][40:33], VEC[i][32:25], VEC[i][24:17]);
      check($sformatf("table row %0d", i), VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
    end

    // R6: equal values loaded directly freeze at once
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'd9, 8'd9, 8'd3);
    check("R6 equal load", 8'd9, 8'd9, 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 8'd3);
    check("R8 equal freeze holds", 8'd9, 8'd9, 1'b1);

    // R5: step equal to count reaches zero without wrapping
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 8'd3, 8'd3);
    check("R3 reload", 8'd1, 8'd3, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'd0, 8'd0, 8'd3);
    check("R5 exact step to zero", 8'd1, 8'd0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 8'd3);
    check("R6 meet at zero", 8'd0, 8'd0, 1'b1);

    // R1: reset overrides strobes mid-run
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'd40, 8'd30, 8'd3);
    check("R1 reset overrides load", 8'd0, 8'd0, 1'b1);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 8'd3);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule